// File: doc/BRIEF.md
# Paired-Page Fully-Associative TLB Lookup

This block is a fully-associative translation buffer in which every entry covers two neighbouring virtual pages, an even one and an odd one, sharing a single tag. Each entry carries its own page-size exponent. The width of the tag compare and the address bit that picks between the two page descriptors therefore change from entry to entry. A write port loads a whole entry at an index: one tag word and two page descriptors. A lookup port takes a 48-bit virtual address and the current address-space identifier.

The lookup is combinational over registered entry storage. In the same cycle it returns a hit, a page-invalid flag, a one-hot vector naming the winning entry, the 48-bit physical address, and the attribute bits of the selected page. The block reports only misses and invalid pages. Permission decisions are left to the logic that consumes the attributes.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset every entry is disabled, so every lookup misses until an entry is written.
- R2: An entry takes part in a match only when its enable bit (tag bit 0) is 1, and either its global bit (tag bit 11) is 1 or its 10-bit identifier (tag bits 10:1) equals the lookup identifier.
- R3: With page exponent P (tag bits 17:12, legal range 12 to 46), an entry matches when virtual address bits 47 down to P+1 equal the same bits of the pair base. The pair base is the tag field at bits 52:18 placed at address bits 47:13.
- R4: Address bit P selects the descriptor: 0 selects the even descriptor and 1 selects the odd one.
- R5: The physical address is the selected descriptor's page number (descriptor bits 44:9) shifted left by 12, OR-ed with virtual address bits P-1:0.
- R6: The attribute outputs carry the selected descriptor's fields: valid bit 0, dirty bit 1, no-read bit 2, no-execute bit 3, memory type bits 5:4, privilege level bits 7:6, restricted-privilege bit 8.
- R7: When several entries match, the lowest-indexed one wins, and the match vector is one-hot at that index.
- R8: A match whose selected descriptor has valid bit 0 raises the page-invalid output and keeps hit low. A match on a valid descriptor raises hit and keeps page-invalid low.
- R9: A write becomes visible to lookups from the next cycle. A lookup made in the same cycle as a write sees the entry's previous contents.
- R10: When nothing matches, hit, page-invalid, the match vector, the physical address and all attributes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | IDX_W | Entry index to load |
| wr_tag | input | 53 | Tag word of the entry |
| wr_even | input | 45 | Even-page descriptor |
| wr_odd | input | 45 | Odd-page descriptor |
| lk_va | input | 48 | Virtual address to translate |
| lk_asid | input | 10 | Current address-space identifier |
| lk_hit | output | 1 | Match on a valid page |
| lk_page_inval | output | 1 | Match on a page whose valid bit is clear |
| lk_match_vec | output | NUM_ENTRIES | One-hot winning entry, zero on a miss |
| lk_pa | output | 48 | Physical address |
| lk_v | output | 1 | Selected page valid bit |
| lk_d | output | 1 | Selected page dirty bit |
| lk_nr | output | 1 | Selected page no-read bit |
| lk_nx | output | 1 | Selected page no-execute bit |
| lk_mat | output | 2 | Selected page memory type |
| lk_plv | output | 2 | Selected page privilege level |
| lk_rplv | output | 1 | Selected page restricted-privilege bit |

## Verification
A write and a lookup can fall in the same cycle. The bench provokes this by driving a load and a lookup of the same address on one falling edge, once into an empty slot and once over a live entry whose page number changes. The response sampled before the rising edge must equal the reference computed from the old entry contents. The lookup repeated one cycle later must match the reference built from the new contents.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  localparam int VA_W       = 48;
  localparam int PA_W       = 48;
  localparam int ASID_W     = 10;
  localparam int PS_W       = 6;
  localparam int BASE_SHIFT = 12;
  localparam int PAIR_SHIFT = 13;
  localparam int VPPN_W     = VA_W - PAIR_SHIFT;
  localparam int PPN_W      = PA_W - BASE_SHIFT;

  // tag word layout
  localparam int T_E       = 0;
  localparam int T_ASID_LO = 1;
  localparam int T_G       = T_ASID_LO + ASID_W;
  localparam int T_PS_LO   = T_G + 1;
  localparam int T_VPPN_LO = T_PS_LO + PS_W;
  localparam int TAG_W     = T_VPPN_LO + VPPN_W;

  // descriptor layout: attribute bits below the page number
  localparam int ATTR_W    = 9;
  localparam int D_PPN_LO  = ATTR_W;
  localparam int DESC_W    = D_PPN_LO + PPN_W;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DESC_W-1:0] desc_t;
  typedef logic [VA_W-1:0]   va_t;
  typedef logic [PA_W-1:0]   pa_t;

  typedef struct packed {
    logic       rplv;
    logic [1:0] plv;
    logic [1:0] mat;
    logic       nx;
    logic       nr;
    logic       d;
    logic       v;
  } attr_t;

  function automatic logic [PS_W-1:0] tag_ps(input tag_t t);
    return t[T_PS_LO +: PS_W];
  endfunction

  function automatic logic [ASID_W-1:0] tag_asid(input tag_t t);
    return t[T_ASID_LO +: ASID_W];
  endfunction

  function automatic va_t tag_base(input tag_t t);
    return {t[T_VPPN_LO +: VPPN_W], {PAIR_SHIFT{1'b0}}};
  endfunction

  // address bits above the pair (ps+1 and up)
  function automatic va_t pair_hi_mask(input logic [PS_W-1:0] ps);
    va_t ones;
    ones = '1;
    return ones << (int'(ps) + 1);
  endfunction

  // address bits inside one page (below ps)
  function automatic va_t page_lo_mask(input logic [PS_W-1:0] ps);
    va_t ones;
    ones = '1;
    return ~(ones << int'(ps));
  endfunction

  function automatic logic tag_hits(input tag_t t, input va_t va,
                                    input logic [ASID_W-1:0] asid);
    logic owner_ok;
    logic page_ok;
    owner_ok = t[T_G] || (tag_asid(t) == asid);
    page_ok  = ((va ^ tag_base(t)) & pair_hi_mask(tag_ps(t))) == '0;
    return t[T_E] && owner_ok && page_ok;
  endfunction

  function automatic logic [PPN_W-1:0] desc_ppn(input desc_t d);
    return d[D_PPN_LO +: PPN_W];
  endfunction

  function automatic attr_t desc_attr(input desc_t d);
    return attr_t'(d[ATTR_W-1:0]);
  endfunction

  function automatic pa_t make_pa(input logic [PPN_W-1:0] ppn, input va_t va,
                                  input logic [PS_W-1:0] ps);
    return {ppn, {BASE_SHIFT{1'b0}}} | pa_t'(va & page_lo_mask(ps));
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pair_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  tag_t                     wr_tag,
  input  desc_t                    wr_even,
  input  desc_t                    wr_odd,
  output logic [N-1:0][TAG_W-1:0]  tags,
  output logic [N-1:0][DESC_W-1:0] evens,
  output logic [N-1:0][DESC_W-1:0] odds
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        tags[i]  <= '0;
        evens[i] <= '0;
        odds[i]  <= '0;
      end
    end else if (wr_en) begin
      tags[wr_idx]  <= wr_tag;
      evens[wr_idx] <= wr_even;
      odds[wr_idx]  <= wr_odd;
    end
  end
endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlb_pair_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  va_t                     va,
  input  logic [ASID_W-1:0]       asid,
  output logic [N-1:0]            match_raw
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_raw[g] = tag_hits(tags[g], va, asid);
  end
endmodule

// File: rtl/tlb_priority_pick.sv
module tlb_priority_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     match_raw,
  output logic [N-1:0]     match_oh,
  output logic [IDX_W-1:0] sel_idx,
  output logic             any_match
);
  assign match_oh  = match_raw & (~match_raw + 1'b1);
  assign any_match = |match_raw;

  always_comb begin
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_raw[i]) sel_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic [DESC_W-1:0]      wr_even,
  input  logic [DESC_W-1:0]      wr_odd,
  input  logic [VA_W-1:0]        lk_va,
  input  logic [ASID_W-1:0]      lk_asid,
  output logic                   lk_hit,
  output logic                   lk_page_inval,
  output logic [NUM_ENTRIES-1:0] lk_match_vec,
  output logic [PA_W-1:0]        lk_pa,
  output logic                   lk_v,
  output logic                   lk_d,
  output logic                   lk_nr,
  output logic                   lk_nx,
  output logic [1:0]             lk_mat,
  output logic [1:0]             lk_plv,
  output logic                   lk_rplv
);
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]  tags;
  logic [NUM_ENTRIES-1:0][DESC_W-1:0] evens;
  logic [NUM_ENTRIES-1:0][DESC_W-1:0] odds;

  // named internal events for the checker
  logic [NUM_ENTRIES-1:0] match_raw;
  logic [NUM_ENTRIES-1:0] match_oh;
  logic [IDX_W-1:0]       sel_idx;
  logic                   any_match;
  logic                   odd_half;
  tag_t                   sel_tag;
  desc_t                  sel_desc;
  attr_t                  sel_attr;
  logic [PS_W-1:0]        sel_ps;

  tlb_entry_store #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_even (wr_even),
    .wr_odd  (wr_odd),
    .tags    (tags),
    .evens   (evens),
    .odds    (odds)
  );

  tlb_match_unit #(.N(NUM_ENTRIES)) u_match (
    .tags      (tags),
    .va        (lk_va),
    .asid      (lk_asid),
    .match_raw (match_raw)
  );

  tlb_priority_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .match_raw (match_raw),
    .match_oh  (match_oh),
    .sel_idx   (sel_idx),
    .any_match (any_match)
  );

  assign sel_tag  = tags[sel_idx];
  assign sel_ps   = tag_ps(sel_tag);
  assign odd_half = lk_va[sel_ps];
  assign sel_desc = odd_half ? odds[sel_idx] : evens[sel_idx];
  assign sel_attr = any_match ? desc_attr(sel_desc) : '0;

  assign lk_match_vec  = match_oh;
  assign lk_hit        = any_match &  sel_attr.v;
  assign lk_page_inval = any_match & ~sel_attr.v;
  assign lk_pa         = any_match ? make_pa(desc_ppn(sel_desc), lk_va, sel_ps) : '0;
  assign lk_v          = sel_attr.v;
  assign lk_d          = sel_attr.d;
  assign lk_nr         = sel_attr.nr;
  assign lk_nx         = sel_attr.nx;
  assign lk_mat        = sel_attr.mat;
  assign lk_plv        = sel_attr.plv;
  assign lk_rplv       = sel_attr.rplv;
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [11:0]  va_lo,
  input logic         hit,
  input logic         inval,
  input logic         v,
  input logic [47:0]  pa,
  input logic [N-1:0] match_vec,
  input logic [N-1:0] match_raw
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (match_vec == '0));

  assert_onehot_winner_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  assert_winner_is_match_R7: assert property (@(posedge clk) disable iff (rst)
    (match_vec & ~match_raw) == '0);

  assert_winner_present_R7: assert property (@(posedge clk) disable iff (rst)
    (match_raw != '0) |-> (match_vec != '0));

  assert_hit_inval_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(hit && inval));

  assert_hit_valid_R8: assert property (@(posedge clk) disable iff (rst)
    hit |-> v);

  assert_inval_not_valid_R8: assert property (@(posedge clk) disable iff (rst)
    inval |-> !v);

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pa[11:0] == va_lo));

  assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (match_vec == '0) |-> (!hit && !inval && pa == '0));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .va_lo     (lk_va[11:0]),
  .hit       (lk_hit),
  .inval     (lk_page_inval),
  .v         (lk_v),
  .pa        (lk_pa),
  .match_vec (lk_match_vec),
  .match_raw (match_raw)
);

// File: tb/tlb_pair_lookup_bench.sv
module tlb_pair_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [52:0]   wr_tag = '0;
  logic [44:0]   wr_even = '0;
  logic [44:0]   wr_odd = '0;
  logic [47:0]   lk_va = '0;
  logic [9:0]    lk_asid = '0;
  logic          lk_hit, lk_page_inval, lk_v, lk_d, lk_nr, lk_nx, lk_rplv;
  logic [NE-1:0] lk_match_vec;
  logic [47:0]   lk_pa;
  logic [1:0]    lk_mat, lk_plv;

  int vectors = 0;
  int miscompares = 0;

  logic [52:0] m_tag  [NE];
  logic [44:0] m_even [NE];
  logic [44:0] m_odd  [NE];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_pair_lookup #(.NUM_ENTRIES(NE)) u_tlb_pair_lookup (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_even(wr_even), .wr_odd(wr_odd), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_page_inval(lk_page_inval), .lk_match_vec(lk_match_vec),
    .lk_pa(lk_pa), .lk_v(lk_v), .lk_d(lk_d), .lk_nr(lk_nr), .lk_nx(lk_nx),
    .lk_mat(lk_mat), .lk_plv(lk_plv), .lk_rplv(lk_rplv)
  );

  function automatic logic [52:0] mk_tag(input bit e, input int asid, input bit g,
                                         input int ps, input longint unsigned base);
    logic [52:0] t;
    t = '0;
    t[0] = e;
    t[10:1] = asid[9:0];
    t[11] = g;
    t[17:12] = ps[5:0];
    t[52:18] = base[47:13];
    return t;
  endfunction

  function automatic logic [44:0] mk_desc(input bit v, input bit d, input bit nr,
                                          input bit nx, input int mat, input int plv,
                                          input bit rplv, input longint unsigned ppn);
    return {ppn[35:0], rplv, plv[1:0], mat[1:0], nx, nr, d, v};
  endfunction

  // reference built arithmetically from the requirements
  task automatic compare(input string req);
    logic [70:0] expv, actv;
    logic [NE-1:0] ev;
    longint unsigned va, pnum, ppn, pa, vpair, tpair;
    int ps, win;
    logic [44:0] dsc;
    va = longint'(lk_va);
    win = -1;
    for (int i = 0; i < NE; i++) begin
      ps = int'(m_tag[i][17:12]);
      vpair = va >> (ps + 1);
      tpair = longint'(m_tag[i][52:18]) >> (ps + 1 - 13);
      if (win < 0 && m_tag[i][0] && (m_tag[i][11] || m_tag[i][10:1] == lk_asid)
          && vpair == tpair) win = i;
    end
    ev = '0;
    if (win < 0) begin
      expv = '0;
    end else begin
      ev[win] = 1'b1;
      ps = int'(m_tag[win][17:12]);
      pnum = (va >> ps) % 2;
      dsc = (pnum == 1) ? m_odd[win] : m_even[win];
      ppn = longint'(dsc[44:9]);
      pa = (ppn * 64'd4096) | (va % (64'd1 << ps));
      expv = {dsc[0], !dsc[0], ev, pa[47:0], dsc[8:0]};
    end
    actv = {lk_hit, lk_page_inval, lk_match_vec, lk_pa,
            lk_rplv, lk_plv, lk_mat, lk_nx, lk_nr, lk_d, lk_v};
    vectors++;
    if (actv !== expv) begin
      miscompares++;
      $display("FAIL %s va=%h asid=%0d act=%h exp=%h", req, lk_va, lk_asid, actv, expv);
    end
  endtask

  task automatic look(input longint unsigned va, input int asid, input string req);
    @(negedge clk);
    lk_va = va[47:0];
    lk_asid = asid[9:0];
    #1;
    compare(req);
  endtask

  task automatic load(input int idx, input logic [52:0] t, input logic [44:0] e,
                      input logic [44:0] o);
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = idx[IW-1:0];
    wr_tag = t;
    wr_even = e;
    wr_odd = o;
    @(posedge clk);
    #1;
    m_tag[idx] = t;
    m_even[idx] = e;
    m_odd[idx] = o;
    wr_en = 1'b0;
  endtask

  // R9: write and lookup in one cycle; result must reflect old contents
  task automatic load_and_look(input int idx, input logic [52:0] t, input logic [44:0] e,
                               input logic [44:0] o, input longint unsigned va,
                               input int asid);
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = idx[IW-1:0];
    wr_tag = t;
    wr_even = e;
    wr_odd = o;
    lk_va = va[47:0];
    lk_asid = asid[9:0];
    #1;
    compare("R9 same-cycle old contents");
    @(posedge clk);
    #1;
    m_tag[idx] = t;
    m_even[idx] = e;
    m_odd[idx] = o;
    wr_en = 1'b0;
    look(va, asid, "R9 next-cycle new contents");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired (all requirements) act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int asl[5];
    longint unsigned base, sz, va;
    int ps;
    asl = '{5, 7, 3, 9, 0};
    for (int i = 0; i < NE; i++) begin
      m_tag[i] = '0; m_even[i] = '0; m_odd[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: empty after reset
    look(64'h0, 0, "R1 empty");
    look(64'h0000_1234_6000, 5, "R1 empty");
    look(64'hFFFF_FFFF_FFFF, 1023, "R1 empty");
    for (int k = 0; k < 8; k++) look({$urandom, $urandom}, k, "R1 empty");

    load(0, mk_tag(1, 5, 0, 12, 64'h0000_1234_6000),
         mk_desc(1, 1, 0, 0, 1, 0, 0, 36'h0_00AB_C),
         mk_desc(1, 0, 1, 1, 2, 3, 1, 36'h0_00DE_F));
    load(1, mk_tag(1, 7, 1, 14, 64'h0000_8000_0000),
         mk_desc(1, 0, 0, 1, 3, 1, 0, 36'h1_2345_6),
         mk_desc(1, 1, 1, 0, 0, 2, 1, 36'h2_3456_7));
    load(2, mk_tag(1, 3, 0, 21, 64'h7F00_0040_0000),
         mk_desc(1, 1, 0, 0, 1, 3, 0, 36'h0_0040_0),
         mk_desc(1, 0, 0, 0, 2, 0, 1, 36'h0_00E0_1));
    load(3, mk_tag(0, 5, 0, 12, 64'h0000_0000_2000),
         mk_desc(1, 1, 1, 1, 3, 3, 1, 36'h5_5555_5),
         mk_desc(1, 1, 1, 1, 3, 3, 1, 36'h6_6666_6));
    load(4, mk_tag(1, 5, 0, 16, 64'h0001_0000_0000),
         mk_desc(0, 1, 0, 1, 2, 1, 1, 36'h7_0000_1),
         mk_desc(1, 0, 1, 0, 1, 2, 0, 36'h7_0000_3));
    load(5, mk_tag(1, 9, 1, 14, 64'h0000_8000_0000),
         mk_desc(1, 1, 1, 1, 1, 1, 1, 36'h9_9999_9),
         mk_desc(1, 1, 1, 1, 1, 1, 1, 36'hA_AAAA_A));
    load(6, mk_tag(1, 9, 0, 30, 64'h4000_0000_0000),
         mk_desc(1, 0, 0, 0, 0, 0, 0, 36'h8_0000_0),
         mk_desc(1, 1, 0, 1, 3, 2, 1, 36'hC_0000_5));

    // R2 R3 R4 R5 R6 R10: sweep around every pair boundary for several identifiers
    for (int i = 0; i < 7; i++) begin
      ps = int'(m_tag[i][17:12]);
      base = longint'(m_tag[i][52:18]) << 13;
      sz = 64'd1 << ps;
      for (int a = 0; a < 5; a++) begin
        look(base, asl[a], "R2 R3 R4 R5 R6 R10 sweep even start");
        look(base + sz - 1, asl[a], "R3 R4 R5 sweep even end");
        look(base + sz, asl[a], "R4 R5 R6 sweep odd start");
        look(base + 2 * sz - 1, asl[a], "R3 R4 R5 sweep odd end");
        look(base + 2 * sz, asl[a], "R3 R10 sweep past pair");
        look(base - 1, asl[a], "R3 R10 sweep below pair");
        look(base + (sz >> 1) + 64'h123, asl[a], "R5 R6 sweep mid page");
      end
    end

    // R2: identifier and enable checks
    look(64'h0000_1234_6010, 5, "R2 own identifier hits");
    look(64'h0000_1234_6010, 6, "R2 other identifier misses");
    look(64'h0000_8000_4abc, 1000, "R2 global ignores identifier");
    look(64'h0000_0000_2000, 5, "R2 disabled entry misses");
    // R7: entries 1 and 5 share a pair
    look(64'h0000_8000_1000, 9, "R7 lowest index wins");
    look(64'h0000_8000_7ffc, 0, "R7 lowest index wins odd");
    // R8: even half invalid, odd half valid
    look(64'h0001_0000_1234, 5, "R8 invalid even page");
    look(64'h0001_0001_1234, 5, "R8 valid odd page");

    // R9: same-cycle write into empty slot and over a live entry
    load_and_look(7, mk_tag(1, 2, 0, 13, 64'h0000_00F0_0000),
                  mk_desc(1, 0, 0, 0, 1, 1, 0, 36'h3_0303_0),
                  mk_desc(1, 1, 1, 1, 2, 2, 1, 36'h3_0303_1),
                  64'h0000_00F0_2468, 2);
    load_and_look(0, mk_tag(1, 5, 0, 12, 64'h0000_1234_6000),
                  mk_desc(1, 0, 1, 0, 0, 2, 1, 36'h0_0F00_D),
                  mk_desc(1, 0, 1, 0, 0, 2, 1, 36'h0_0F00_E),
                  64'h0000_1234_6abc, 5);

    // random addresses, half steered near loaded pairs
    for (int k = 0; k < 300; k++) begin
      int e;
      e = k % NE;
      if (k % 2 == 0) va = {$urandom, $urandom};
      else va = (longint'(m_tag[e][52:18]) << 13) + longint'($urandom % 32'h0100_0000);
      look(va, k % 11, "R3 R4 R5 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule